// File: doc/BRIEF.md
# Privilege-Aware Local Interrupt Selector

This block decides which local interrupt a hart should take next. Each interrupt source has a pending bit, an enable bit and a delegation bit. A source is a candidate when it is both pending and enabled. Undelegated candidates are handled at machine level. Delegated candidates are handled at supervisor level.

Each of the two groups has its own global gate. That gate depends on the hart's current privilege and on the matching global enable bit, not on one shared switch. Among the candidates that pass their gate, the lowest-numbered one wins.

The selection logic is combinational. Its result is captured in one output register, so a valid flag and an index appear one clock after the inputs are presented. A trap-entry sequencer samples them to decide whether to redirect the hart and with which cause number.

Top module: `irq_pick`

## Requirements
- R1: A source is a candidate only when its bit is set in both `pend_i` and `en_i`. A pending source that is not enabled is never reported, and neither is an enabled source that is not pending.
- R2: The machine-level gate covers sources whose `deleg_i` bit is 0. It is open when `priv_i` is numerically below 3, or when `priv_i` is 3 and `m_ie_i` is 1. It is closed when `priv_i` is 3 and `m_ie_i` is 0.
- R3: The supervisor-level gate covers sources whose `deleg_i` bit is 1. It is open when `priv_i` is 0, or when `priv_i` is 1 and `s_ie_i` is 1. It is closed in every other case, which includes `priv_i` equal to 3.
- R4: The final set is the union of the undelegated candidates passing the machine gate and the delegated candidates passing the supervisor gate. One group being gated off does not mask the other group.
- R5: When the final set is not empty, `irq_valid_o` is 1 and `irq_idx_o` holds the lowest bit position set in the final set. This covers positions 0 and NUM_IRQ-1.
- R6: When the final set is empty, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R7: The outputs are registered. They reflect the inputs present at the previous rising clock edge and hold steady between edges.
- R8: Reset is synchronous and active high. A rising edge with `rst_i` at 1 drives `irq_valid_o` to 0 and `irq_idx_o` to 0, whatever the inputs are.
- R9: The privilege field is compared numerically: 0 is user, 1 is supervisor, 3 is machine. The unused code 2 therefore opens the machine gate unconditionally and closes the supervisor gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_IRQ | Pending bit per source |
| en_i | input | NUM_IRQ | Enable bit per source |
| deleg_i | input | NUM_IRQ | 1 = source handled at supervisor level |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| irq_valid_o | output | 1 | An interrupt is selected |
| irq_idx_o | output | IDX_W | Index of the selected source |

## Verification
The bench builds the block with its default of 16 sources, giving a 4-bit index. This puts both ends of the priority order in reach: bit 0 and bit 15. Both appear in vectors where a competing source sits in the other delegation group. With two global enables and four privilege codes, every gate combination is small enough to visit, including the unused code 2. Mixed-delegation vectors show one group winning while the other is held off.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // Global gate state for the two handling levels
    typedef struct packed {
        logic mach_open;
        logic super_open;
    } gate_t;

    // Numeric privilege ordering, used for both gates
    function automatic logic lvl_below(input lvl_e cur, input lvl_e ref_lvl);
        return (cur < ref_lvl);
    endfunction

    function automatic logic lvl_at(input lvl_e cur, input lvl_e ref_lvl);
        return (cur == ref_lvl);
    endfunction

endpackage

// File: rtl/irq_pick_gate.sv
module irq_pick_gate
    import irq_pick_pkg::*;
(
    input  lvl_e  lvl_i,
    input  logic  m_ie_i,
    input  logic  s_ie_i,
    output gate_t gate_o
);

    always_comb begin
        gate_o.mach_open  = lvl_below(lvl_i, LVL_MACH)
                          | (lvl_at(lvl_i, LVL_MACH) & m_ie_i);
        gate_o.super_open = lvl_below(lvl_i, LVL_SUPER)
                          | (lvl_at(lvl_i, LVL_SUPER) & s_ie_i);
    end

endmodule

// File: rtl/irq_pick_mask.sv
module irq_pick_mask
    import irq_pick_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  gate_t              gate_i,
    output logic [NUM_IRQ-1:0] final_o
);

    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
        logic cand;
        assign cand = pend_i[b] & en_i[b];
        assign final_o[b] = cand & (deleg_i[b] ? gate_i.super_open : gate_i.mach_open);
    end

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int NUM_IRQ = 16,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] set_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top down so the lowest set bit is written last
    always_comb begin
        idx_o = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            if (set_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
        found_o = |set_i;
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pick_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [NUM_IRQ-1:0] deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_ie_i,
    input  logic               s_ie_i,
    output logic               irq_valid_o,
    output logic [IDX_W-1:0]   irq_idx_o
);

    lvl_e               lvl;
    gate_t              gate;
    logic [NUM_IRQ-1:0] final_set;
    logic               found;
    logic [IDX_W-1:0]   idx_next;

    assign lvl = lvl_e'(priv_i);

    irq_pick_gate u_gate (
        .lvl_i  (lvl),
        .m_ie_i (m_ie_i),
        .s_ie_i (s_ie_i),
        .gate_o (gate)
    );

    irq_pick_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .gate_i  (gate),
        .final_o (final_set)
    );

    irq_pick_lowest #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_low (
        .set_i   (final_set),
        .found_o (found),
        .idx_o   (idx_next)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_valid_o <= 1'b0;
            irq_idx_o   <= '0;
        end else begin
            irq_valid_o <= found;
            irq_idx_o   <= found ? idx_next : '0;
        end
    end

    // R1: a reported source was pending and enabled
    a_r1_cand_was_live: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_valid_o |-> ((($past(pend_i & en_i)) >> irq_idx_o) & NUM_IRQ'(1)) != '0);

    // R2: machine level with its enable clear takes nothing
    a_r2_mach_closed: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(priv_i) == 2'd3 && !$past(m_ie_i)) |-> !irq_valid_o);

    // R3: delegated source reported only when supervisor gate was open
    a_r3_super_gate: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_valid_o && (((($past(deleg_i)) >> irq_idx_o) & NUM_IRQ'(1)) != '0))
        |-> ($past(priv_i) == 2'd0 || ($past(priv_i) == 2'd1 && $past(s_ie_i))));

    // R5: the reported bit is in the gated set and nothing lower is
    a_r5_lowest: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_valid_o |-> (($past(final_set) & ((NUM_IRQ'(1) << irq_idx_o) - NUM_IRQ'(1))) == '0
                         && ((($past(final_set)) >> irq_idx_o) & NUM_IRQ'(1)) != '0));

    // R6: an empty gated set gives no valid and a zero index
    a_r6_empty: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(final_set) == '0) |-> (!irq_valid_o && irq_idx_o == '0));

    // R8: reset clears outputs at the next edge
    a_r8_reset: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!irq_valid_o && irq_idx_o == '0));

endmodule

// File: tb/test_irq_pick.sv
module test_irq_pick;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  pend, en, deleg;
    logic [1:0]    priv;
    logic          mie, sie;
    logic          vld;
    logic [IW-1:0] idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_pick #(.NUM_IRQ(N)) i_irq_pick (
        .clk_i       (clk),
        .rst_i       (rst),
        .pend_i      (pend),
        .en_i        (en),
        .deleg_i     (deleg),
        .priv_i      (priv),
        .m_ie_i      (mie),
        .s_ie_i      (sie),
        .irq_valid_o (vld),
        .irq_idx_o   (idx)
    );

    // {pend, en, deleg, priv, m_ie, s_ie, exp_valid, exp_idx}
    localparam logic [56:0] VEC [NV] = '{
        {16'h0080, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7},   // R2 user
        {16'h0080, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0},   // R1 not enabled
        {16'h0880, 16'h0800, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd11},  // R1 R2
        {16'h0880, 16'h0880, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0},   // R2 closed
        {16'h0022, 16'h0022, 16'h0002, 2'd3, 1'b1, 1'b1, 1'b1, 4'd5},   // R3 R4
        {16'h0022, 16'h0022, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 4'd5},   // R3 R4
        {16'h0022, 16'h0022, 16'h0002, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1},   // R3 R5
        {16'h8001, 16'hFFFF, 16'h0001, 2'd1, 1'b0, 1'b0, 1'b1, 4'd15},  // R4 R5 top
        {16'h8001, 16'hFFFF, 16'h0001, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0},   // R3 R5 bottom
        {16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1'b0, 4'd0},   // R9 super closed
        {16'hFFFF, 16'hFFFF, 16'h0000, 2'd2, 1'b0, 1'b0, 1'b1, 4'd0},   // R9 mach open
        {16'hF000, 16'hF000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd12},  // R5
        {16'h4000, 16'h4000, 16'h4000, 2'd1, 1'b0, 1'b1, 1'b1, 4'd14},  // R3
        {16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0}    // R6 empty
    };

    task automatic check(input string req, input logic gv, input logic [IW-1:0] gi,
                         input logic ev, input logic [IW-1:0] ei);
        checks++;
        if (gv !== ev || gi !== ei) begin
            errors++;
            $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
                     req, gv, gi, ev, ei);
        end
    endtask

    task automatic drive(input logic [56:0] v);
        {pend, en, deleg, priv, mie, sie} = v[56:5];
    endtask

    initial begin
        rst = 1'b1;
        pend = '1; en = '1; deleg = '0; priv = 2'd0; mie = 1'b1; sie = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset state", vld, idx, 1'b0, 4'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive(VEC[n]);
            @(posedge clk);
            #1;
            check($sformatf("R4 vector %0d", n), vld, idx, VEC[n][4], VEC[n][3:0]);
        end

        // R7: new inputs do not show before the next edge
        @(negedge clk);
        pend = 16'h0200; en = 16'h0200; deleg = '0; priv = 2'd0;
        @(posedge clk); #1;
        check("R7 after edge", vld, idx, 1'b1, 4'd9);
        @(negedge clk);
        pend = 16'h0000;
        #1;
        check("R7 held before edge", vld, idx, 1'b1, 4'd9);
        @(posedge clk); #1;
        check("R6 cleared after edge", vld, idx, 1'b0, 4'd0);

        // R8: synchronous reset with an active request
        @(negedge clk);
        pend = 16'h0010; en = 16'h0010;
        @(posedge clk); #1;
        check("R8 pre-reset", vld, idx, 1'b1, 4'd4);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R8 sync, before edge", vld, idx, 1'b1, 4'd4);
        @(posedge clk); #1;
        check("R8 after edge", vld, idx, 1'b0, 4'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R8 resume", vld, idx, 1'b1, 4'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule